// File: doc/BRIEF.md
# Phase-Aligned Carrier and Sampling Timing Generator

This block produces every timing signal of a polarimeter readout from a single reference clock domain. One of two reference sources, an external reference or a local oscillator, is selected and advances a cascade of three modulo counters. The first stage yields the converter sampling strobe. The second counts strobes and toggles the fast modulation carrier. The third counts fast-carrier half periods and toggles the slow modulation carrier. A record strobe marks each full slow-carrier period. Every derived signal comes from the same cascade, so any carrier edge lands on the same clock cycle as a sampling strobe.

The reference choice is modelled as a per-cycle advance enable from each source. A request to change source is held until the next slow-carrier period boundary, so no record period mixes both references. A restart command, taken on its rising edge, clears the whole cascade, puts both carriers high and emits a one-cycle time-reset pulse that downstream time counters use for alignment. With default parameters and a 40 MHz reference, the strobe runs at 800 kHz, the fast carrier at 4 kHz, and the slow carrier and record strobe at 125 Hz.

Top module: `tmg_carrier_gen`

## Requirements
- R1: While reset is asserted, and until the first active reference tick after release, both carriers are high, the sampling, record and time-reset strobes are low, and the active source output is 0 (local).
- R2: The sampling strobe is a one-clock pulse that rises after every ADC_DIV-th active reference tick counted since the last restart.
- R3: The fast carrier toggles after every C1_HALF sampling strobes, and only in a cycle where the sampling strobe is high or a time reset is issued.
- R4: The slow carrier toggles after every C2_RATIO fast-carrier half periods, and only when the fast carrier also toggles or on a time reset; C2_RATIO must be even.
- R5: The record strobe is a one-clock pulse in the cycle where the slow carrier returns high through counting, together with a sampling strobe. It occurs once per slow-carrier period.
- R6: When the active source output is 1, only the external tick input advances the cascade; when it is 0, only the local tick input does. The unselected input has no effect.
- R7: The active source output takes the value of the select input only in a cycle where a record strobe is issued. It holds at every other time.
- R8: A rising edge on the restart request yields exactly one time-reset pulse on the next clock. In that same cycle both carriers are high, no strobe is issued, and counting restarts from zero. Holding the request high produces no further pulse.
- R9: In cycles with no active reference tick, the counters and carriers hold, and no sampling or record strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_tick_i | input | 1 | Advance enable from the external reference |
| loc_tick_i | input | 1 | Advance enable from the local oscillator |
| ref_sel_i | input | 1 | Requested source: 1 external, 0 local |
| restart_req_i | input | 1 | Restart command, acted on at its rising edge |
| adc_strobe_o | output | 1 | Converter sampling strobe |
| carrier1_o | output | 1 | Fast modulation carrier |
| carrier2_o | output | 1 | Slow modulation carrier |
| record_strobe_o | output | 1 | Once-per-slow-period record strobe |
| time_reset_o | output | 1 | One-cycle time-reset pulse |
| ref_active_o | output | 1 | Source currently driving the cascade |

## Verification
The bench switches the requested source partway through a slow period and with ticks coming at half rate from one source. A design that switched at once would shift every later strobe against the counted ticks. It holds the restart request for several cycles and also restarts mid-period. A level-sensitive restart would repeat the time-reset pulse, and a restart that missed a counter would leave the carriers out of phase. It also runs with ticks only on the unselected input and with no ticks at all. Any leakage from the ignored source, or drift while idle, would show up as unexpected strobes or carrier edges.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_EXT   = 1'b1
  } tmg_src_e;

  localparam int TMG_STAGES = 3;

  function automatic int tmg_cnt_width(input int modulus);
    return (modulus < 2) ? 1 : $clog2(modulus);
  endfunction

endpackage

// File: rtl/tmg_rst_sync.sv
module tmg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/tmg_ref_select.sv
module tmg_ref_select
  import tmg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_tick_i,
  input  logic loc_tick_i,
  input  logic req_sel_i,
  input  logic commit_i,
  output logic tick_o,
  output logic active_o
);

  tmg_src_e active_q;
  tmg_src_e active_d;

  always_comb begin
    active_d = active_q;
    if (commit_i) begin
      active_d = tmg_src_e'(req_sel_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= SRC_LOCAL;
    end else begin
      active_q <= active_d;
    end
  end

  assign tick_o   = (active_q == SRC_EXT) ? ext_tick_i : loc_tick_i;
  assign active_o = (active_q == SRC_EXT);

endmodule

// File: rtl/tmg_stage.sv
module tmg_stage #(
  parameter int MODULUS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic restart_i,
  output logic wrap_o
);

  localparam int W = tmg_pkg::tmg_cnt_width(MODULUS);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = adv_i && at_last && !restart_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = at_last ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tmg_carrier_gen.sv
module tmg_carrier_gen
  import tmg_pkg::*;
#(
  parameter int ADC_DIV  = 50,
  parameter int C1_HALF  = 100,
  parameter int C2_RATIO = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_tick_i,
  input  logic loc_tick_i,
  input  logic ref_sel_i,
  input  logic restart_req_i,
  output logic adc_strobe_o,
  output logic carrier1_o,
  output logic carrier2_o,
  output logic record_strobe_o,
  output logic time_reset_o,
  output logic ref_active_o
);

  localparam int LAST = TMG_STAGES - 1;
  localparam int DIVS [TMG_STAGES] = '{ADC_DIV, C1_HALF, C2_RATIO};

  if (ADC_DIV < 2 || C1_HALF < 1 || C2_RATIO < 2 || (C2_RATIO % 2) != 0) begin : g_bad_param
    $error("tmg_carrier_gen: divider parameters out of range or slow ratio odd");
  end

  logic                  rst_sn;
  logic                  tick;
  logic                  restart;
  logic                  commit;
  logic                  req_q;
  logic [TMG_STAGES-1:0] adv;
  logic [TMG_STAGES-1:0] wrap;
  logic [LAST:1]         car_q;
  logic [LAST:1]         car_d;
  logic                  strobe_q, strobe_d;
  logic                  rec_q, rec_d;
  logic                  trst_q, trst_d;

  tmg_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sn)
  );

  assign restart = restart_req_i && !req_q;
  assign commit  = wrap[LAST] && !car_q[LAST];

  tmg_ref_select u_ref_select (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .ext_tick_i (ext_tick_i),
    .loc_tick_i (loc_tick_i),
    .req_sel_i  (ref_sel_i),
    .commit_i   (commit),
    .tick_o     (tick),
    .active_o   (ref_active_o)
  );

  for (genvar g = 0; g < TMG_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign adv[g] = tick && !restart;
    end else begin : g_tail
      assign adv[g] = wrap[g-1];
    end
    tmg_stage #(.MODULUS(DIVS[g])) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_sn),
      .adv_i     (adv[g]),
      .restart_i (restart),
      .wrap_o    (wrap[g])
    );
  end

  always_comb begin
    for (int k = 1; k <= LAST; k++) begin
      if (restart) begin
        car_d[k] = 1'b1;
      end else if (wrap[k]) begin
        car_d[k] = !car_q[k];
      end else begin
        car_d[k] = car_q[k];
      end
    end
    strobe_d = wrap[0];
    rec_d    = commit;
    trst_d   = restart;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      car_q    <= '1;
      strobe_q <= 1'b0;
      rec_q    <= 1'b0;
      trst_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      car_q    <= car_d;
      strobe_q <= strobe_d;
      rec_q    <= rec_d;
      trst_q   <= trst_d;
      req_q    <= restart_req_i;
    end
  end

  assign adc_strobe_o    = strobe_q;
  assign carrier1_o      = car_q[1];
  assign carrier2_o      = car_q[LAST];
  assign record_strobe_o = rec_q;
  assign time_reset_o    = trst_q;

endmodule

// File: rtl/tmg_carrier_gen_chk.sv
module tmg_carrier_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_strobe_o,
  input logic carrier1_o,
  input logic carrier2_o,
  input logic record_strobe_o,
  input logic time_reset_o,
  input logic ref_active_o
);

  // R2: the sampling strobe never lasts two cycles (ADC_DIV >= 2)
  p_strobe_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_strobe_o |=> !adc_strobe_o);

  // R3: fast carrier moves only with a strobe or a restart
  p_c1_on_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carrier1_o) |-> (adc_strobe_o || time_reset_o));

  // R4: slow carrier moves only with the fast carrier or a restart
  p_c2_on_c1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carrier2_o) |-> (!$stable(carrier1_o) || time_reset_o));

  // R5: record strobe sits on a high slow carrier and a sampling strobe
  p_rec_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    record_strobe_o |-> (carrier2_o && adc_strobe_o && !time_reset_o));

  // R7: active source changes only at a record boundary
  p_sel_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_active_o) |-> record_strobe_o);

  // R8: time reset is a single-cycle pulse
  p_trst_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_reset_o |=> !time_reset_o);

  // R8: restart leaves a defined phase
  p_trst_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_reset_o |-> (carrier1_o && carrier2_o && !adc_strobe_o));

endmodule

bind tmg_carrier_gen tmg_carrier_gen_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .adc_strobe_o    (adc_strobe_o),
  .carrier1_o      (carrier1_o),
  .carrier2_o      (carrier2_o),
  .record_strobe_o (record_strobe_o),
  .time_reset_o    (time_reset_o),
  .ref_active_o    (ref_active_o)
);

// File: tb/tb_tmg_carrier_gen.sv
module tb_tmg_carrier_gen;

  localparam int A  = 4;
  localparam int H  = 3;
  localparam int RT = 4;
  localparam int P1 = A * H;
  localparam int P2 = P1 * RT;

  // vector: [15] select, [14:13] ext pattern, [12:11] loc pattern,
  // [10] restart request, [9:0] cycles. Pattern 0 off, 1 on, 2 alternate.
  localparam int NSEG = 9;
  localparam logic [15:0] SEGS [NSEG] = '{
    {1'b0, 2'd0, 2'd1, 1'b0, 10'd220},
    {1'b1, 2'd1, 2'd2, 1'b0, 10'd60},
    {1'b1, 2'd1, 2'd0, 1'b0, 10'd200},
    {1'b0, 2'd2, 2'd1, 1'b0, 10'd300},
    {1'b0, 2'd0, 2'd1, 1'b1, 10'd4},
    {1'b0, 2'd0, 2'd1, 1'b0, 10'd70},
    {1'b0, 2'd0, 2'd1, 1'b1, 10'd1},
    {1'b0, 2'd0, 2'd1, 1'b0, 10'd130},
    {1'b1, 2'd2, 2'd1, 1'b0, 10'd250}
  };

  logic clk;
  logic rst_n;
  logic ext_tick, loc_tick, ref_sel, restart_req;
  logic adc_strobe, carrier1, carrier2, record_strobe, time_reset, ref_active;

  int n_checks;
  int n_fail;
  bit done;
  int cyc;
  int t;
  bit e_str, e_c1, e_c2, e_rec, e_trst, e_sel, req_prev;
  int strobes_seen;

  tmg_carrier_gen #(.ADC_DIV(A), .C1_HALF(H), .C2_RATIO(RT)) dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .ext_tick_i      (ext_tick),
    .loc_tick_i      (loc_tick),
    .ref_sel_i       (ref_sel),
    .restart_req_i   (restart_req),
    .adc_strobe_o    (adc_strobe),
    .carrier1_o      (carrier1),
    .carrier2_o      (carrier2),
    .record_strobe_o (record_strobe),
    .time_reset_o    (time_reset),
    .ref_active_o    (ref_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    t = 0; e_str = 0; e_c1 = 1; e_c2 = 1; e_rec = 0; e_trst = 0;
    e_sel = 0; req_prev = 0;
  endtask

  function automatic logic pat(input logic [1:0] p, input int c);
    return (p == 2'd1) ? 1'b1 : (p == 2'd2) ? logic'(c[0]) : 1'b0;
  endfunction

  // Called at a negedge: drive inputs, predict the next edge, compare after it.
  task automatic step(input logic sel, input logic [1:0] ep, input logic [1:0] lp,
                      input logic req);
    bit tk;
    ref_sel = sel;
    ext_tick = pat(ep, cyc);
    loc_tick = pat(lp, cyc);
    restart_req = req;
    tk = e_sel ? ext_tick : loc_tick;
    if (req && !req_prev) begin
      t = 0; e_str = 0; e_c1 = 1; e_c2 = 1; e_rec = 0; e_trst = 1;
    end else begin
      e_trst = 0;
      if (tk) begin
        t++;
        e_str = (t % A) == 0;
        e_c1  = ((t / P1) % 2) == 0;
        e_c2  = ((t / P2) % 2) == 0;
        e_rec = (t % (2 * P2)) == 0;
        if (e_rec) e_sel = sel;
      end else begin
        e_str = 0; e_rec = 0;
      end
    end
    req_prev = req;
    @(negedge clk);
    cyc++;
    strobes_seen += int'(adc_strobe);
    chk("R2 sampling strobe", adc_strobe, e_str);
    chk("R3 fast carrier", carrier1, e_c1);
    chk("R4 slow carrier", carrier2, e_c2);
    chk("R5 record strobe", record_strobe, e_rec);
    chk("R8 time reset", time_reset, e_trst);
    chk("R7 active source (R6 tick source)", ref_active, e_sel);
  endtask

  task automatic check_reset_state(input string tag);
    chk({"R1 strobe ", tag}, adc_strobe, 0);
    chk({"R1 fast carrier ", tag}, carrier1, 1);
    chk({"R1 slow carrier ", tag}, carrier2, 1);
    chk({"R1 record ", tag}, record_strobe, 0);
    chk({"R1 time reset ", tag}, time_reset, 0);
    chk({"R1 source ", tag}, ref_active, 0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_reset_state("after release");
    model_reset();
  endtask

  initial begin
    int c1_before, c2_before;
    n_checks = 0; n_fail = 0; done = 0; cyc = 0; strobes_seen = 0;
    rst_n = 1'b0; ext_tick = 0; loc_tick = 0; ref_sel = 0; restart_req = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_reset_state("in reset");
    release_reset();

    // table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEGS[s][9:0]); k++) begin
        step(SEGS[s][15], SEGS[s][14:13], SEGS[s][12:11], SEGS[s][10]);
      end
    end

    // R9: no ticks at all, everything holds
    c1_before = int'(carrier1);
    c2_before = int'(carrier2);
    strobes_seen = 0;
    for (int k = 0; k < 80; k++) step(e_sel, 2'd0, 2'd0, 1'b0);
    chk("R9 strobes while idle", strobes_seen, 0);
    chk("R9 fast carrier held", int'(carrier1), c1_before);
    chk("R9 slow carrier held", int'(carrier2), c2_before);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run");
    release_reset();

    // R6: local source active, ticks only on external input
    strobes_seen = 0;
    for (int k = 0; k < 60; k++) step(1'b0, 2'd1, 2'd0, 1'b0);
    chk("R6 ignored external ticks", strobes_seen, 0);
    chk("R6 source still local", int'(ref_active), 0);

    // R8: restart right after reset with request held
    for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 2'd1, 1'b1);
    for (int k = 0; k < 30; k++) step(1'b0, 2'd0, 2'd1, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule